// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor link. It steps one coprocessor instruction at a time through its execute stage. An issue strobe arrives together with a condition flag. When the condition holds, the sequencer enters execute and raises `pass_o` for every execute cycle. In each of those cycles it reads a 2-bit handshake code from the coprocessor. The first execute cycle reads that code from a dedicated bus. Every later execute cycle reads it from a second bus. The code either holds the instruction in execute, commits it, or rejects it as undefined.

For a register-to-coprocessor transfer, the register value is captured at issue. That value appears on the outbound data bus, with a valid flag, only in the commit cycle. For a coprocessor-to-register transfer, the cycle after commit acts as the memory stage. The inbound data bus is sampled at the end of that cycle, and the sampled word is written to the destination register one cycle later through a write-enable strobe.

Top module: `cp_hs_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, the following outputs are low or zero: `pass_o`, `commit_o`, `undef_o`, `out_valid_o`, `rd_we_o`, `out_data_o` and `rd_data_o`. A reset during execute abandons the instruction at once.
- R2: The sequencer accepts an instruction at a clock edge when it is idle and samples `issue_i` and `cond_ok_i` both high. The cycle after that edge is the first execute cycle. `pass_o` is high in every execute cycle and low in every other cycle.
- R3: An issue with `cond_ok_i` low is not executed. `pass_o`, `commit_o` and `undef_o` stay low, and both handshake buses are ignored, even when they carry the last-cycle code.
- R4: In the first execute cycle the handshake code is taken from `hs_first_i`, and `hs_next_i` has no effect.
- R5: In every execute cycle after the first, the code is taken from `hs_next_i`, and `hs_first_i` has no effect.
- R6: The code values are 2'b00 absent, 2'b01 wait, 2'b10 go and 2'b11 last. Wait and go both keep the instruction in execute for one more cycle.
- R7: A last code makes `commit_o` high in that same execute cycle and ends execute.
- R8: An absent code makes `undef_o` high in that same cycle, keeps `commit_o` low, and ends the instruction with no transfer.
- R9: When `dir_to_cp_i` was 1 at issue (register to coprocessor), the commit cycle shows the `src_data_i` value captured at issue on `out_data_o`, and `out_valid_o` is high. In every other cycle `out_valid_o` is low and `out_data_o` is zero.
- R10: When `dir_to_cp_i` was 0 at issue (coprocessor to register), the cycle after commit is the memory stage. `in_data_i` is sampled at the end of that cycle, and `pass_o` is low during it.
- R11: In the cycle after the sample, `rd_we_o` is high for exactly one cycle. At that time `rd_data_o` holds the sampled word and `rd_idx_o` holds the `dst_idx_i` value captured at issue.
- R12: `issue_i` is ignored while an instruction is in execute or in the memory stage. The captured source data is kept, and no new execute phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction issued to execute |
| cond_ok_i | input | 1 | Condition codes pass |
| dir_to_cp_i | input | 1 | 1 = register to coprocessor, 0 = coprocessor to register |
| src_data_i | input | DATA_W | Source register value, captured at issue |
| dst_idx_i | input | IDX_W | Destination register index, captured at issue |
| hs_first_i | input | 2 | Handshake code for the first execute cycle |
| hs_next_i | input | 2 | Handshake code for later execute cycles |
| in_data_i | input | DATA_W | Inbound data from the coprocessor |
| pass_o | output | 1 | Instruction is in execute with its condition passed |
| commit_o | output | 1 | Instruction committed this cycle |
| undef_o | output | 1 | Coprocessor is absent; undefined instruction |
| out_data_o | output | DATA_W | Outbound register data |
| out_valid_o | output | 1 | Outbound data valid |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | IDX_W | Destination register index |
| rd_data_o | output | DATA_W | Destination register write data |

## Verification
Each execute cycle drives the unused handshake bus with the inverse of the live code. A sequencer that read the wrong bus would then commit where it should reject, or swap wait and go, so its cycle count would change. Failed-condition issues put the last code on both buses, and a block that did not gate on the condition would pulse `pass_o` or `commit_o`. The inbound bus changes value in the write-back cycle, so sampling one cycle early or late shows up as a wrong `rd_data_o` or a misplaced `rd_we_o`. Re-issues during execute and during the memory stage carry new source data, and a design that accepted them would corrupt the outbound word or raise `pass_o` again.

// File: rtl/cp_hs_pkg.sv
package cp_hs_pkg;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_EX1  = 2'b01,
    ST_EXN  = 2'b10,
    ST_MEM  = 2'b11
  } seq_state_e;

endpackage

// File: rtl/cp_hs_sel.sv
module cp_hs_sel
  import cp_hs_pkg::*;
(
  input  logic       first_i,
  input  logic [1:0] hs_first_i,
  input  logic [1:0] hs_next_i,
  output hs_code_e   code_o
);

  always_comb begin
    if (first_i) code_o = hs_code_e'(hs_first_i);
    else         code_o = hs_code_e'(hs_next_i);
  end

endmodule

// File: rtl/cp_hs_fsm.sv
module cp_hs_fsm
  import cp_hs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     issue_i,
  input  logic     cond_ok_i,
  input  logic     to_cp_i,
  input  hs_code_e code_i,
  output logic     accept_o,
  output logic     first_o,
  output logic     in_ex_o,
  output logic     commit_o,
  output logic     undef_o,
  output logic     mem_o
);

  seq_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && issue_i && cond_ok_i;
  assign first_o  = (state_q == ST_EX1);
  assign in_ex_o  = (state_q == ST_EX1) || (state_q == ST_EXN);
  assign mem_o    = (state_q == ST_MEM);
  assign commit_o = in_ex_o && (code_i == HS_LAST);
  assign undef_o  = in_ex_o && (code_i == HS_ABSENT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_EX1;
      ST_EX1, ST_EXN: begin
        unique case (code_i)
          HS_LAST:   state_d = to_cp_i ? ST_IDLE : ST_MEM;
          HS_ABSENT: state_d = ST_IDLE;
          default:   state_d = ST_EXN;
        endcase
      end
      ST_MEM:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/cp_hs_datapath.sv
module cp_hs_datapath #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              dir_to_cp_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic              commit_i,
  input  logic              mem_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              to_cp_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              rd_we_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] src_q;
  logic [IDX_W-1:0]  idx_q;
  logic              to_cp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      idx_q   <= '0;
      to_cp_q <= 1'b0;
    end else if (accept_i) begin
      src_q   <= src_data_i;
      idx_q   <= dst_idx_i;
      to_cp_q <= dir_to_cp_i;
    end
  end

  assign to_cp_o     = to_cp_q;
  assign out_valid_o = commit_i && to_cp_q;
  assign out_data_o  = out_valid_o ? src_q : '0;

  // memory-stage sample, written back the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_we_o   <= 1'b0;
      rd_idx_o  <= '0;
      rd_data_o <= '0;
    end else begin
      rd_we_o <= mem_i;
      if (mem_i) begin
        rd_idx_o  <= idx_q;
        rd_data_o <= in_data_i;
      end
    end
  end

endmodule

// File: rtl/cp_hs_seq.sv
module cp_hs_seq
  import cp_hs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              cond_ok_i,
  input  logic              dir_to_cp_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [1:0]        hs_first_i,
  input  logic [1:0]        hs_next_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              pass_o,
  output logic              commit_o,
  output logic              undef_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              rd_we_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] rd_data_o
);

  hs_code_e code;
  logic     accept, first, in_ex, mem, to_cp;

  cp_hs_sel i_sel (
    .first_i    (first),
    .hs_first_i (hs_first_i),
    .hs_next_i  (hs_next_i),
    .code_o     (code)
  );

  cp_hs_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue_i),
    .cond_ok_i (cond_ok_i),
    .to_cp_i   (to_cp),
    .code_i    (code),
    .accept_o  (accept),
    .first_o   (first),
    .in_ex_o   (in_ex),
    .commit_o  (commit_o),
    .undef_o   (undef_o),
    .mem_o     (mem)
  );

  cp_hs_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .dir_to_cp_i (dir_to_cp_i),
    .src_data_i  (src_data_i),
    .dst_idx_i   (dst_idx_i),
    .commit_i    (commit_o),
    .mem_i       (mem),
    .in_data_i   (in_data_i),
    .to_cp_o     (to_cp),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .rd_we_o     (rd_we_o),
    .rd_idx_o    (rd_idx_o),
    .rd_data_o   (rd_data_o)
  );

  assign pass_o = in_ex;

endmodule

// File: rtl/cp_hs_seq_chk.sv
module cp_hs_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              cond_ok_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              pass_o,
  input logic              commit_o,
  input logic              undef_o,
  input logic              out_valid_o,
  input logic              rd_we_o,
  input logic [DATA_W-1:0] rd_data_o
);

  a_r2_pass_needs_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> $past(issue_i && cond_ok_i));

  a_r7_commit_in_ex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> pass_o);

  a_r8_undef_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (pass_o && !commit_o));

  a_r9_valid_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> commit_o);

  a_r10_mem_no_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> !$past(pass_o));

  a_r11_wb_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_data_o == $past(in_data_i)));

  a_r11_wb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |=> !rd_we_o);

endmodule

bind cp_hs_seq cp_hs_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_i     (issue_i),
  .cond_ok_i   (cond_ok_i),
  .in_data_i   (in_data_i),
  .pass_o      (pass_o),
  .commit_o    (commit_o),
  .undef_o     (undef_o),
  .out_valid_o (out_valid_o),
  .rd_we_o     (rd_we_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/test_cp_hs_seq.sv
`timescale 1ns/1ps
module test_cp_hs_seq;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic              cond;
    logic              to_cp;
    logic [1:0]        c0;
    logic [1:0]        c1;
    logic [1:0]        c2;
    logic [1:0]        c3;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] din;
  } vec_t;

  // codes: 00 absent, 01 wait, 10 go, 11 last
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 4'h1, 32'hA5A5_0001, 32'h0000_0000},
    '{1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 4'h7, 32'h0000_0000, 32'hCAFE_F00D},
    '{1'b1, 1'b1, 2'b01, 2'b10, 2'b11, 2'b00, 4'h2, 32'h1234_5678, 32'h0000_0000},
    '{1'b1, 1'b0, 2'b10, 2'b01, 2'b01, 2'b11, 4'hC, 32'h0000_0000, 32'h8765_4321},
    '{1'b1, 1'b1, 2'b00, 2'b11, 2'b11, 2'b11, 4'h3, 32'hDEAD_BEEF, 32'h0000_0000},
    '{1'b1, 1'b0, 2'b01, 2'b00, 2'b11, 2'b11, 4'h4, 32'h0000_0000, 32'h5555_AAAA},
    '{1'b0, 1'b1, 2'b11, 2'b11, 2'b11, 2'b11, 4'h5, 32'hFFFF_0000, 32'h0000_0000},
    '{1'b1, 1'b0, 2'b10, 2'b11, 2'b00, 2'b00, 4'hF, 32'h0000_0000, 32'h0F0F_F0F0}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              issue_i = 1'b0;
  logic              cond_ok_i = 1'b0;
  logic              dir_to_cp_i = 1'b0;
  logic [DATA_W-1:0] src_data_i = '0;
  logic [IDX_W-1:0]  dst_idx_i = '0;
  logic [1:0]        hs_first_i = 2'b00;
  logic [1:0]        hs_next_i = 2'b00;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              pass_o, commit_o, undef_o, out_valid_o, rd_we_o;
  logic [DATA_W-1:0] out_data_o, rd_data_o;
  logic [IDX_W-1:0]  rd_idx_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  cp_hs_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_cp_hs_seq (
    .clk_i, .rst_ni, .issue_i, .cond_ok_i, .dir_to_cp_i, .src_data_i,
    .dst_idx_i, .hs_first_i, .hs_next_i, .in_data_i, .pass_o, .commit_o,
    .undef_o, .out_data_o, .out_valid_o, .rd_we_o, .rd_idx_o, .rd_data_o
  );

  task automatic chk(input logic ok, input string req,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(pass_o == 1'b0 && commit_o == 1'b0 && undef_o == 1'b0 && out_valid_o == 1'b0,
        req, {28'd0, pass_o, commit_o, undef_o, out_valid_o}, 32'd0);
    chk(out_data_o == '0, req, out_data_o, 32'd0);
  endtask

  task automatic issue(input logic cond, input logic to_cp,
                       input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] src);
    @(negedge clk_i);
    issue_i = 1'b1; cond_ok_i = cond; dir_to_cp_i = to_cp;
    dst_idx_i = idx; src_data_i = src;
    hs_first_i = 2'b11; hs_next_i = 2'b11;
  endtask

  task automatic run_vec(input vec_t v);
    logic [1:0] code;
    logic       done, committed;
    issue(v.cond, v.to_cp, v.idx, v.src);
    if (!v.cond) begin
      @(negedge clk_i);
      issue_i = 1'b0; hs_first_i = 2'b11; hs_next_i = 2'b11;
      #1 chk_idle("R3");
      @(negedge clk_i);
      #1 chk_idle("R3");
      return;
    end
    done = 1'b0; committed = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!done) begin
        case (k)
          0: code = v.c0;
          1: code = v.c1;
          2: code = v.c2;
          default: code = v.c3;
        endcase
        @(negedge clk_i);
        issue_i = 1'b0; src_data_i = ~v.src;
        if (k == 0) begin hs_first_i = code; hs_next_i = ~code; end
        else        begin hs_next_i = code;  hs_first_i = ~code; end
        #1;
        chk(pass_o == 1'b1, "R2", {31'd0, pass_o}, 32'd1);
        chk(commit_o == (code == 2'b11), (k == 0) ? "R4 R7" : "R5 R7",
            {31'd0, commit_o}, {31'd0, code == 2'b11});
        chk(undef_o == (code == 2'b00), (k == 0) ? "R4 R8" : "R5 R8",
            {31'd0, undef_o}, {31'd0, code == 2'b00});
        chk(out_valid_o == (code == 2'b11 && v.to_cp), "R9",
            {31'd0, out_valid_o}, {31'd0, code == 2'b11 && v.to_cp});
        chk(out_data_o == ((code == 2'b11 && v.to_cp) ? v.src : '0), "R9",
            out_data_o, (code == 2'b11 && v.to_cp) ? v.src : '0);
        if (code == 2'b11) begin done = 1'b1; committed = 1'b1; end
        if (code == 2'b00) done = 1'b1;
      end
    end
    if (committed && !v.to_cp) begin
      @(negedge clk_i);
      in_data_i = v.din;
      #1;
      chk(pass_o == 1'b0 && rd_we_o == 1'b0, "R10", {30'd0, pass_o, rd_we_o}, 32'd0);
      @(negedge clk_i);
      in_data_i = ~v.din;
      #1;
      chk(rd_we_o == 1'b1, "R11", {31'd0, rd_we_o}, 32'd1);
      chk(rd_data_o == v.din, "R10 R11", rd_data_o, v.din);
      chk(rd_idx_o == v.idx, "R11", {28'd0, rd_idx_o}, {28'd0, v.idx});
      chk(pass_o == 1'b0, "R2", {31'd0, pass_o}, 32'd0);
      @(negedge clk_i);
      #1 chk(rd_we_o == 1'b0, "R11", {31'd0, rd_we_o}, 32'd0);
    end else begin
      @(negedge clk_i);
      #1 chk_idle("R6");
      chk(rd_we_o == 1'b0, "R11", {31'd0, rd_we_o}, 32'd0);
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 chk_idle("R1");
    chk(rd_we_o == 1'b0 && rd_data_o == '0, "R1", rd_data_o, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 chk_idle("R1");

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R12: re-issue during execute keeps captured data
    issue(1'b1, 1'b1, 4'h6, 32'h0BAD_C0DE);
    @(negedge clk_i);
    issue_i = 1'b0; hs_first_i = 2'b01; hs_next_i = 2'b10;
    @(negedge clk_i);
    issue_i = 1'b1; cond_ok_i = 1'b1; dir_to_cp_i = 1'b0; src_data_i = 32'h1111_2222;
    hs_next_i = 2'b10; hs_first_i = 2'b00;
    #1 chk(pass_o == 1'b1 && commit_o == 1'b0, "R12", {31'd0, pass_o}, 32'd1);
    @(negedge clk_i);
    issue_i = 1'b0; hs_next_i = 2'b11; hs_first_i = 2'b00;
    #1 chk(out_valid_o && out_data_o == 32'h0BAD_C0DE, "R12 R9", out_data_o, 32'h0BAD_C0DE);
    @(negedge clk_i);
    #1 chk_idle("R12");

    // R12: issue during memory stage is ignored
    issue(1'b1, 1'b0, 4'h9, 32'h0);
    @(negedge clk_i);
    issue_i = 1'b0; hs_first_i = 2'b11; hs_next_i = 2'b00;
    @(negedge clk_i);
    issue_i = 1'b1; cond_ok_i = 1'b1; in_data_i = 32'h3C3C_3C3C;
    @(negedge clk_i);
    issue_i = 1'b0; in_data_i = '0;
    #1 chk(pass_o == 1'b0, "R12", {31'd0, pass_o}, 32'd0);
    chk(rd_we_o && rd_data_o == 32'h3C3C_3C3C && rd_idx_o == 4'h9, "R11",
        rd_data_o, 32'h3C3C_3C3C);
    @(negedge clk_i);
    #1 chk_idle("R12");

    // R1: reset in the middle of execute
    issue(1'b1, 1'b1, 4'h2, 32'h7777_7777);
    @(negedge clk_i);
    issue_i = 1'b0; hs_first_i = 2'b01; hs_next_i = 2'b11;
    #1 chk(pass_o == 1'b1, "R2", {31'd0, pass_o}, 32'd1);
    rst_ni = 1'b0;
    #1 chk_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 chk_idle("R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule